// File: doc/BRIEF.md
# Regular Conversion Result Completion and DMA Request Logic

This block sits behind an analog-to-digital converter's regular conversion path. Each time a conversion finishes, it takes the raw result and stores it right or left justified in a wide data register. It then decides whether to raise the completion flag and whether the result has overwritten one that nobody collected. It also decides whether to ask a DMA engine to move the value.

Three mode inputs set the behaviour. The completion-granularity bit chooses between flagging every conversion and flagging only the last conversion of a sequence. The DMA enable bit turns request generation on. The continuation bit chooses what happens once the DMA side reports its final transfer: either requests keep coming, or they stop until DMA mode is switched off and back on. A software read of the data register, or a DMA acknowledge, collects the current result.

Top module: `adc_result_ctrl`

## Requirements
- R1: After reset, `data_o`, `eoc_o`, `ovr_o` and `dma_req_o` are all 0.
- R2: With `align_left_i`=0, a conversion strobe loads the result into `data_o[11:0]` with bits 15:12 at 0, visible one cycle after the strobe.
- R3: With `align_left_i`=1, a conversion strobe loads the result into `data_o[15:4]` with bits 3:0 at 0, visible one cycle after the strobe.
- R4: With `eoc_each_i`=1, every conversion strobe sets `eoc_o` one cycle later.
- R5: With `eoc_each_i`=0, a conversion strobe sets `eoc_o` only if `seq_end_i` is high with it; otherwise `eoc_o` is left unchanged.
- R6: A data read (`dr_read_i`) or a DMA acknowledge (`dma_ack_i`) with no strobe in the same cycle clears `eoc_o` and `dma_req_o` one cycle later.
- R7: With `eoc_each_i`=1, a strobe that arrives while the previous result is still uncollected (no read or acknowledge since it) sets `ovr_o` one cycle later. The new result still replaces the data.
- R8: With `eoc_each_i`=0, overrun detection follows `dma_en_i`: it behaves as in R7 when `dma_en_i`=1, and `ovr_o` never sets when `dma_en_i`=0.
- R9: `ovr_o` stays set until a cycle with `ovr_clr_i`=1, which clears it one cycle later.
- R10: While `dma_en_i`=0, `dma_req_o` is 0.
- R11: With `dma_en_i`=1 and `dma_cont_i`=1, every strobe raises `dma_req_o` one cycle later, including after an acknowledge with `dma_last_i`=1.
- R12: With `dma_en_i`=1 and `dma_cont_i`=0, an acknowledge with `dma_last_i`=1 stops requests. Later strobes raise no request until `dma_en_i` has been 0 for at least one cycle and is set to 1 again.
- R13: Dropping `dma_en_i` to 0 withdraws a pending request one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done_i | input | 1 | One-cycle strobe: a regular conversion finished |
| conv_res_i | input | 12 | Raw conversion result, valid with the strobe |
| seq_end_i | input | 1 | The strobed conversion is the last of its sequence |
| eoc_each_i | input | 1 | 1: flag every conversion; 0: flag sequence ends |
| align_left_i | input | 1 | 1: left justify; 0: right justify |
| dma_en_i | input | 1 | DMA request mode enable |
| dma_cont_i | input | 1 | 1: keep requesting after the final transfer |
| dr_read_i | input | 1 | Software read of the data register |
| dma_ack_i | input | 1 | DMA engine collected the result |
| dma_last_i | input | 1 | Qualifies an acknowledge as the final transfer |
| ovr_clr_i | input | 1 | Write-zero clear of the overrun flag |
| data_o | output | 16 | Justified result register |
| eoc_o | output | 1 | Completion flag |
| ovr_o | output | 1 | Sticky overrun flag |
| dma_req_o | output | 1 | DMA request line |

## Verification
Every output is a flop. The effect of any input sampled at a rising edge is therefore due exactly one cycle later, and a strobe with a result, a read, an acknowledge, a clear or a mode change all follow the same rule. The bench drives each step at the falling edge and pushes the expected outputs into a queue. A monitor pops one entry at every rising edge and compares it one time unit after that edge, so each expectation is compared at the single edge where its effect first appears. Mode bits are changed only inside a step, so a mode change takes effect on the same edge as the stimulus it belongs to.

// File: rtl/adc_rc_pkg.sv
package adc_rc_pkg;

   // Run-time mode bits gathered from the top-level ports
   typedef struct packed {
      logic eoc_each;
      logic align_left;
      logic dma_en;
      logic dma_cont;
   } rc_mode_t;

   // Events that collect the current result
   typedef struct packed {
      logic sw_read;
      logic dma_ack;
   } rc_take_t;

   function automatic logic taken(input rc_take_t t);
      return t.sw_read | t.dma_ack;
   endfunction

endpackage

// File: rtl/adc_rc_align.sv
module adc_rc_align #(
   parameter int RES_W = 12,
   parameter int DR_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             left_i,
   input  logic [RES_W-1:0] res_i,
   output logic [DR_W-1:0]  data_o
);

   localparam int PAD_W = DR_W - RES_W;

   logic [DR_W-1:0] right_w;
   logic [DR_W-1:0] left_w;

   generate
      if (RES_W < 1) begin : g_bad_res
         $error("adc_rc_align: RES_W must be at least 1");
      end
      if (PAD_W < 0) begin : g_bad_width
         $error("adc_rc_align: DR_W must not be narrower than RES_W");
      end else if (PAD_W == 0) begin : g_flush
         assign right_w = res_i;
         assign left_w  = res_i;
      end else begin : g_pad
         assign right_w = {{PAD_W{1'b0}}, res_i};
         assign left_w  = {res_i, {PAD_W{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
      end else if (load_i) begin
         data_o <= left_i ? left_w : right_w;
      end
   end

   generate
      if (PAD_W > 0) begin : g_chk
         // R2: right justified results keep the top bits clear
         p_right_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
            load_i && !left_i |=> data_o[DR_W-1:RES_W] == '0);
         // R3: left justified results keep the low bits clear
         p_left_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
            load_i && left_i |=> data_o[PAD_W-1:0] == '0);
      end
   endgenerate

   p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(data_o));

endmodule

// File: rtl/adc_rc_flags.sv
module adc_rc_flags
   import adc_rc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     done_i,
   input  logic     seq_end_i,
   input  rc_take_t take_i,
   input  logic     ovr_clr_i,
   input  rc_mode_t mode_i,
   output logic     eoc_o,
   output logic     ovr_o
);

   logic pend_q;
   logic take_w;
   logic flag_now_w;
   logic ovr_arm_w;
   logic ovr_hit_w;

   assign take_w     = taken(take_i);
   assign flag_now_w = done_i & (mode_i.eoc_each | seq_end_i);
   assign ovr_arm_w  = mode_i.eoc_each | mode_i.dma_en;
   assign ovr_hit_w  = done_i & pend_q & ~take_w & ovr_arm_w;

   // An uncollected result is outstanding
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (done_i)  pend_q <= 1'b1;
      else if (take_w)  pend_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          eoc_o <= 1'b0;
      else if (flag_now_w) eoc_o <= 1'b1;
      else if (take_w)     eoc_o <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ovr_o <= 1'b0;
      else if (ovr_hit_w) ovr_o <= 1'b1;
      else if (ovr_clr_i) ovr_o <= 1'b0;
   end

   p_eoc_every_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_i && mode_i.eoc_each |=> eoc_o);
   p_eoc_seq_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_i && !mode_i.eoc_each && !seq_end_i && !eoc_o |=> !eoc_o);
   p_take_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i.sw_read || take_i.dma_ack) && !done_i |=> !eoc_o);
   p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_i && pend_q && !(take_i.sw_read || take_i.dma_ack) && mode_i.eoc_each |=> ovr_o);
   p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_o && !mode_i.eoc_each && !mode_i.dma_en |=> !ovr_o);
   p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o && !ovr_clr_i |=> ovr_o);

endmodule

// File: rtl/adc_rc_dma.sv
module adc_rc_dma
   import adc_rc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     done_i,
   input  rc_take_t take_i,
   input  logic     last_i,
   input  rc_mode_t mode_i,
   output logic     req_o
);

   logic halt_q;
   logic halt_now_w;
   logic allow_w;

   assign halt_now_w = take_i.dma_ack & last_i & ~mode_i.dma_cont;
   assign allow_w    = mode_i.dma_cont | ~(halt_q | (take_i.dma_ack & last_i));

   // Stop latch, released only by switching DMA mode off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              halt_q <= 1'b0;
      else if (!mode_i.dma_en) halt_q <= 1'b0;
      else if (halt_now_w)     halt_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     req_o <= 1'b0;
      else if (!mode_i.dma_en)        req_o <= 1'b0;
      else if (done_i && allow_w)     req_o <= 1'b1;
      else if (taken(take_i))         req_o <= 1'b0;
   end

   p_no_req_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_i.dma_en |=> !req_o);
   p_req_cont_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_i && mode_i.dma_en && mode_i.dma_cont |=> req_o);
   p_halted_r12: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q && mode_i.dma_en && !mode_i.dma_cont && !req_o |=> !req_o);
   p_take_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i.sw_read || take_i.dma_ack) && !done_i |=> !req_o);

endmodule

// File: rtl/adc_result_ctrl.sv
module adc_result_ctrl
   import adc_rc_pkg::*;
#(
   parameter int RES_W = 12,
   parameter int DR_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_done_i,
   input  logic [RES_W-1:0] conv_res_i,
   input  logic             seq_end_i,
   input  logic             eoc_each_i,
   input  logic             align_left_i,
   input  logic             dma_en_i,
   input  logic             dma_cont_i,
   input  logic             dr_read_i,
   input  logic             dma_ack_i,
   input  logic             dma_last_i,
   input  logic             ovr_clr_i,
   output logic [DR_W-1:0]  data_o,
   output logic             eoc_o,
   output logic             ovr_o,
   output logic             dma_req_o
);

   rc_mode_t mode_w;
   rc_take_t take_w;

   assign mode_w = '{eoc_each: eoc_each_i, align_left: align_left_i,
                     dma_en: dma_en_i, dma_cont: dma_cont_i};
   assign take_w = '{sw_read: dr_read_i, dma_ack: dma_ack_i};

   adc_rc_align #(.RES_W(RES_W), .DR_W(DR_W)) u_align (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (conv_done_i),
      .left_i (mode_w.align_left),
      .res_i  (conv_res_i),
      .data_o (data_o)
   );

   adc_rc_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (conv_done_i),
      .seq_end_i (seq_end_i),
      .take_i    (take_w),
      .ovr_clr_i (ovr_clr_i),
      .mode_i    (mode_w),
      .eoc_o     (eoc_o),
      .ovr_o     (ovr_o)
   );

   adc_rc_dma u_dma (
      .clk    (clk),
      .rst_n  (rst_n),
      .done_i (conv_done_i),
      .take_i (take_w),
      .last_i (dma_last_i),
      .mode_i (mode_w),
      .req_o  (dma_req_o)
   );

   // R13: losing DMA mode withdraws the request
   p_req_withdraw_r13: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req_o && !dma_en_i |=> !dma_req_o);

endmodule

// File: tb/test_adc_result_ctrl.sv
module test_adc_result_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_done_i = 1'b0;
   logic [11:0] conv_res_i = '0;
   logic        seq_end_i = 1'b0;
   logic        eoc_each_i = 1'b0;
   logic        align_left_i = 1'b0;
   logic        dma_en_i = 1'b0;
   logic        dma_cont_i = 1'b0;
   logic        dr_read_i = 1'b0;
   logic        dma_ack_i = 1'b0;
   logic        dma_last_i = 1'b0;
   logic        ovr_clr_i = 1'b0;
   logic [15:0] data_o;
   logic        eoc_o;
   logic        ovr_o;
   logic        dma_req_o;

   always #5 clk = ~clk;

   adc_result_ctrl i_adc_result_ctrl (
      .clk(clk), .rst_n(rst_n), .conv_done_i(conv_done_i), .conv_res_i(conv_res_i),
      .seq_end_i(seq_end_i), .eoc_each_i(eoc_each_i), .align_left_i(align_left_i),
      .dma_en_i(dma_en_i), .dma_cont_i(dma_cont_i), .dr_read_i(dr_read_i),
      .dma_ack_i(dma_ack_i), .dma_last_i(dma_last_i), .ovr_clr_i(ovr_clr_i),
      .data_o(data_o), .eoc_o(eoc_o), .ovr_o(ovr_o), .dma_req_o(dma_req_o)
   );

   typedef struct {
      logic [15:0] d;
      logic        e;
      logic        o;
      logic        r;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   ended = 1'b0;

   // mode bits requested for the next step
   logic nx_each = 0, nx_left = 0, nx_dma = 0, nx_cont = 0;
   // model state, derived from the requirements
   logic [15:0] m_d = '0;
   logic m_e = 0, m_o = 0, m_r = 0, m_pend = 0, m_halt = 0;

   task automatic cmp(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
      end
   endtask

   // driver: apply one cycle of stimulus and push the expected outcome
   task automatic step(input logic done, input logic [11:0] res, input logic se,
                       input logic rd, input logic ack, input logic last,
                       input logic oclr, input string tag);
      logic take, arm, allow;
      exp_t x;
      @(negedge clk);
      eoc_each_i = nx_each; align_left_i = nx_left; dma_en_i = nx_dma; dma_cont_i = nx_cont;
      conv_done_i = done; conv_res_i = res; seq_end_i = se;
      dr_read_i = rd; dma_ack_i = ack; dma_last_i = last; ovr_clr_i = oclr;
      take  = rd | ack;
      arm   = nx_each | nx_dma;
      allow = nx_cont | ~(m_halt | (ack & last));
      if (done) m_d = nx_left ? {res, 4'h0} : {4'h0, res};
      if (done && m_pend && !take && arm) m_o = 1;
      else if (oclr) m_o = 0;
      if (done && (nx_each || se)) m_e = 1;
      else if (take) m_e = 0;
      if (!nx_dma) m_r = 0;
      else if (done && allow) m_r = 1;
      else if (take) m_r = 0;
      if (!nx_dma) m_halt = 0;
      else if (ack && last && !nx_cont) m_halt = 1;
      if (done) m_pend = 1;
      else if (take) m_pend = 0;
      x.d = m_d; x.e = m_e; x.o = m_o; x.r = m_r; x.tag = tag;
      q.push_back(x);
   endtask

   task automatic idle(input string tag);
      step(0, '0, 0, 0, 0, 0, 0, tag);
   endtask

   // monitor: one expectation per edge, compared just after the edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t x;
         x = q.pop_front();
         cmp(x.tag, "data", data_o, x.d);
         cmp(x.tag, "eoc", {15'h0, eoc_o}, {15'h0, x.e});
         cmp(x.tag, "ovr", {15'h0, ovr_o}, {15'h0, x.o});
         cmp(x.tag, "req", {15'h0, dma_req_o}, {15'h0, x.r});
      end
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      cmp("R1", "data", data_o, 16'h0);
      cmp("R1", "flags", {13'h0, eoc_o, ovr_o, dma_req_o}, 16'h0);
      rst_n = 1'b1;
      idle("R1 idle after reset");

      // R2 / R4: right justified, flag on every conversion
      nx_each = 1;
      step(1, 12'hABC, 0, 0, 0, 0, 0, "R2 R4 right justify");
      idle("R4 flag holds");
      step(0, '0, 0, 1, 0, 0, 0, "R6 read clears flag");
      // R3: left justified
      nx_left = 1;
      step(1, 12'h5A5, 0, 0, 0, 0, 0, "R3 left justify");
      step(1, 12'hFFF, 0, 0, 0, 0, 0, "R7 overrun when uncollected");
      idle("R9 overrun sticky");
      step(0, '0, 0, 1, 0, 0, 0, "R9 read keeps overrun");
      step(0, '0, 0, 0, 0, 0, 1, "R9 clear overrun");
      step(1, 12'h123, 0, 0, 0, 0, 0, "R3 load again");
      step(1, 12'h456, 0, 1, 0, 0, 0, "R7 read with new strobe avoids overrun");
      step(0, '0, 0, 1, 0, 0, 0, "R6 read");

      // R5 / R8: sequence granularity, no DMA
      nx_each = 0; nx_left = 0;
      step(1, 12'h001, 0, 0, 0, 0, 0, "R5 mid sequence no flag");
      step(1, 12'h002, 1, 0, 0, 0, 0, "R5 R8 sequence end flags, no overrun");
      step(1, 12'h003, 1, 0, 0, 0, 0, "R8 no overrun without DMA");
      idle("R8 overrun stays clear");
      step(0, '0, 0, 1, 0, 0, 0, "R6 read");

      // R8 with DMA: overrun armed; R6 ack clears
      nx_dma = 1; nx_cont = 1;
      step(1, 12'h010, 0, 0, 0, 0, 0, "R11 request on result");
      step(1, 12'h020, 1, 0, 0, 0, 0, "R8 overrun with DMA");
      step(0, '0, 0, 0, 1, 0, 0, "R6 ack clears flag and request");
      step(0, '0, 0, 0, 0, 0, 1, "R9 clear");
      // R11: continuation keeps requesting after final transfer
      step(1, 12'h030, 0, 0, 0, 0, 0, "R11 request");
      step(0, '0, 0, 0, 1, 1, 0, "R11 final ack");
      step(1, 12'h040, 0, 0, 0, 0, 0, "R11 request after final");
      step(0, '0, 0, 0, 1, 0, 0, "R6 ack");

      // R10: DMA off
      nx_dma = 0;
      step(1, 12'h050, 0, 0, 0, 0, 0, "R10 no request with DMA off");
      step(0, '0, 0, 1, 0, 0, 0, "R10 read");

      // R12: stop after final transfer
      nx_dma = 1; nx_cont = 0;
      step(1, 12'h060, 0, 0, 0, 0, 0, "R12 request before final");
      step(0, '0, 0, 0, 1, 1, 0, "R12 final ack");
      step(1, 12'h070, 0, 0, 0, 0, 0, "R12 halted no request");
      step(0, '0, 0, 1, 0, 0, 0, "R12 read");
      step(1, 12'h080, 0, 0, 0, 0, 0, "R12 still halted");
      step(0, '0, 0, 1, 0, 0, 0, "R12 read");
      nx_dma = 0;
      idle("R12 DMA off");
      nx_dma = 1;
      step(1, 12'h090, 0, 0, 0, 0, 0, "R12 resumed after re-enable");
      // R13: dropping DMA withdraws request
      nx_dma = 0;
      idle("R13 request withdrawn");
      step(0, '0, 0, 1, 0, 0, 1, "R13 tidy");
      idle("R13 settle");

      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule